// File: doc/BRIEF.md
# Automatic USB DMA Packet Sequencer

This block runs one USB endpoint on its own, packet after packet, and moves each packet between the endpoint FIFO and system memory. Software picks a direction, an initial DATA0/DATA1 toggle and an optional packet count, then sets the auto bit. The sequencer flushes the FIFO and enables the endpoint. On receive, it waits for a packet, checks the packet's toggle and length, and copies the bytes to memory. On transmit, it fetches a full packet from memory and then enables the transmitter. The expected toggle flips after every packet that completes.

Auto mode stops as soon as any of four event flags is raised: engine error or toggle mismatch, oversize packet, packet count exhausted, or software halt. The flags stay set until software clears them by writing 1. They drive an interrupt line, even when auto mode is off. Software can stop the sequencer in two ways. Clearing the auto bit and the DMA enable together stops at once. Clearing the auto bit alone lets a DMA burst that is under way finish first. Both ways report a halt event.

The USB packet engine is modelled as a handshake with enable levels and a one-cycle done pulse. The memory side is a request/acknowledge pair that moves one byte for each accepted cycle.

Top module: `aseq_top`

## Requirements
- R1: A control write with the auto bit set starts auto mode only if three things hold: the stored DMA enable is 0, all event bits are 0, and the sequencer is idle. Otherwise auto status stays 0 and no endpoint enable rises.
- R2: An accepted start raises `ep_flush` for exactly one cycle. The endpoint is then enabled in the direction written with the start: `ctl_dir`=0 is receive, 1 is transmit.
- R3: On receive, `ep_rx_en` is held until `ep_done`. Exactly `ep_len` bytes are then requested with `dma_wr`=1 while the receiver is off. After that the receiver is enabled again.
- R4: On transmit, exactly PKT_MAX bytes are requested with `dma_wr`=0. Only then is `ep_tx_en` raised, with `ep_tx_tgl` equal to the next-toggle value.
- R5: Every control write loads next-toggle from `ctl_tgl` (1 = DATA1, 0 = DATA0). Next-toggle inverts after each completed packet.
- R6: On receive, if `ep_rx_tgl` differs from next-toggle, the sequencer sets the error bit and moves no bytes. It does not do this when the ignore-toggle bit is set, which is 0 after reset.
- R7: An `ep_done` with `ep_err`=1 sets the error bit. A received `ep_len` greater than PKT_MAX sets the size bit. In neither case is any byte moved.
- R8: A packet count loaded through `cnt_we` decrements on each completed packet. When it reaches zero, the count bit is set and auto mode ends. A loaded count of 0 means unlimited.
- R9: Clearing the auto bit with `ctl_den`=1 takes effect in one of two ways. In a wait state, the sequencer halts at the next edge. In a DMA state, all remaining bytes are moved first. The halt bit is set on the same edge that the sequencer becomes idle.
- R10: A single control write that clears both the auto bit and `ctl_den` while active does three things one cycle later: `dma_req` is low, the halt bit is set, and no further byte is moved.
- R11: Whenever an event bit is set by the hardware, auto status is 0 from the next cycle on.
- R12: The event bit positions are 0 = error, 1 = size, 2 = count and 3 = halt. Writing 1 through `ev_we`/`ev_clr` clears a bit. A hardware set in the same cycle as a clear wins.
- R13: `irq` is 1 exactly when any event bit is set, whether or not auto mode is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_auto | input | 1 | Auto-mode bit written |
| ctl_den | input | 1 | DMA enable bit written |
| ctl_tgl | input | 1 | Initial toggle written (1 = DATA1) |
| ctl_ign | input | 1 | Ignore receive toggle bit written |
| ctl_dir | input | 1 | Direction, 0 receive, 1 transmit |
| ev_we | input | 1 | Event clear strobe |
| ev_clr | input | 4 | Write-1-to-clear mask for event bits |
| cnt_we | input | 1 | Packet count load strobe |
| cnt_wdata | input | CNT_W | Packet count value, 0 = unlimited |
| ep_flush | output | 1 | FIFO flush pulse |
| ep_rx_en | output | 1 | Receiver enable |
| ep_tx_en | output | 1 | Transmitter enable |
| ep_tx_tgl | output | 1 | Toggle to send with the transmit packet |
| ep_done | input | 1 | Packet engine done pulse |
| ep_err | input | 1 | Packet engine failure, valid with done |
| ep_rx_tgl | input | 1 | Toggle of received packet, valid with done |
| ep_len | input | LEN_W | Received byte count, valid with done |
| dma_req | output | 1 | Byte transfer request |
| dma_wr | output | 1 | 1 = write to memory (receive), 0 = read |
| dma_ack | input | 1 | Byte accepted in this cycle |
| st_auto | output | 1 | Auto mode active bit |
| st_den | output | 1 | Stored DMA enable |
| st_ntgl | output | 1 | Next-toggle bit |
| ev_bits | output | 4 | Event bits |
| irq | output | 1 | Interrupt, any event bit set |

## Verification
The sharp case is an event clear that falls in the same cycle as a hardware set of the same bit. The bench arms a receive and waits for the receiver enable. It then drives a failing done pulse and a write-1-to-clear of the error bit on the same falling edge, so both reach the same rising edge. The outcome passes only if the error bit reads 1 afterwards and the interrupt stays high. The bench also pairs a graceful halt with a stalled DMA burst, to show that the halt waits for the remaining bytes.

// File: rtl/aseq_pkg.sv
package aseq_pkg;

  localparam int EV_N    = 4;
  localparam int EV_ERR  = 0;
  localparam int EV_SIZE = 1;
  localparam int EV_CNT  = 2;
  localparam int EV_HALT = 3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FLUSH,
    S_RX_WAIT,
    S_RX_DMA,
    S_TX_DMA,
    S_TX_WAIT
  } seq_state_e;

  // Event update: clear by mask first, hardware set overrides.
  function automatic logic [EV_N-1:0] ev_next(input logic [EV_N-1:0] cur,
                                              input logic [EV_N-1:0] clr,
                                              input logic [EV_N-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  // Received length accepted when it fits in one packet buffer.
  function automatic logic len_fits(input int len, input int max_len);
    return len <= max_len;
  endfunction

endpackage

// File: rtl/aseq_evreg.sv
module aseq_evreg
  import aseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_we,
  input  logic [EV_N-1:0] clr_mask,
  input  logic [EV_N-1:0] hw_set,
  output logic [EV_N-1:0] ev_q,
  output logic            irq
);

  logic [EV_N-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= ev_next(ev_q, clr_eff, hw_set);
  end

  assign irq = |ev_q;

endmodule

// File: rtl/aseq_pktcnt.sv
module aseq_pktcnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (load)                   cnt_q <= load_val;
    else if (dec && cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/aseq_bytecnt.sv
module aseq_bytecnt #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             step,
  output logic             empty
);

  logic [LEN_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rem_q <= '0;
    else if (load)               rem_q <= load_val;
    else if (step && !empty)     rem_q <= rem_q - LEN_W'(1);
  end

  assign empty = (rem_q == '0);

endmodule

// File: rtl/aseq_top.sv
module aseq_top
  import aseq_pkg::*;
#(
  parameter int PKT_MAX = 8,
  parameter int CNT_W   = 8,
  parameter int LEN_W   = $clog2(PKT_MAX + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ctl_auto,
  input  logic             ctl_den,
  input  logic             ctl_tgl,
  input  logic             ctl_ign,
  input  logic             ctl_dir,
  input  logic             ev_we,
  input  logic [3:0]       ev_clr,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic             ep_flush,
  output logic             ep_rx_en,
  output logic             ep_tx_en,
  output logic             ep_tx_tgl,
  input  logic             ep_done,
  input  logic             ep_err,
  input  logic             ep_rx_tgl,
  input  logic [LEN_W-1:0] ep_len,
  output logic             dma_req,
  output logic             dma_wr,
  input  logic             dma_ack,
  output logic             st_auto,
  output logic             st_den,
  output logic             st_ntgl,
  output logic [3:0]       ev_bits,
  output logic             irq
);

  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(PKT_MAX);

  seq_state_e st_q, st_d;
  logic auto_q, den_q, ign_q, dir_q, ntgl_q;

  // Named internal events, brought out for the checker.
  logic            active;
  logic            start_ok;
  logic            hard_stop;
  logic            halt_pend;
  logic            pkt_done;
  logic [EV_N-1:0] hw_set;
  logic            blen_load;
  logic [LEN_W-1:0] blen_val;
  logic            blen_empty;
  logic            cnt_last;
  logic            rx_tgl_bad;
  logic            len_ok;
  logic            in_dma;

  assign active     = (st_q != S_IDLE);
  assign start_ok   = ctl_we && ctl_auto && !auto_q && !den_q && (ev_bits == '0) && !active;
  assign hard_stop  = ctl_we && !ctl_auto && !ctl_den && active;
  assign halt_pend  = active && !auto_q;
  assign rx_tgl_bad = (ep_rx_tgl != ntgl_q) && !ign_q;
  assign len_ok     = len_fits(int'(ep_len), PKT_MAX);
  assign in_dma     = (st_q == S_RX_DMA) || (st_q == S_TX_DMA);

  always_comb begin
    st_d      = st_q;
    hw_set    = '0;
    pkt_done  = 1'b0;
    blen_load = 1'b0;
    blen_val  = FULL_LEN;
    unique case (st_q)
      S_IDLE: begin
        if (start_ok) st_d = S_FLUSH;
      end
      S_FLUSH: begin
        if (halt_pend) begin
          st_d = S_IDLE;
          hw_set[EV_HALT] = 1'b1;
        end else if (dir_q) begin
          st_d      = S_TX_DMA;
          blen_load = 1'b1;
        end else begin
          st_d = S_RX_WAIT;
        end
      end
      S_RX_WAIT: begin
        if (ep_done) begin
          if (ep_err) begin
            st_d = S_IDLE;
            hw_set[EV_ERR] = 1'b1;
          end else if (!len_ok) begin
            st_d = S_IDLE;
            hw_set[EV_SIZE] = 1'b1;
          end else if (rx_tgl_bad) begin
            st_d = S_IDLE;
            hw_set[EV_ERR] = 1'b1;
          end else begin
            st_d      = S_RX_DMA;
            blen_load = 1'b1;
            blen_val  = ep_len;
          end
        end else if (halt_pend) begin
          st_d = S_IDLE;
          hw_set[EV_HALT] = 1'b1;
        end
      end
      S_RX_DMA: begin
        if (blen_empty) begin
          pkt_done        = 1'b1;
          hw_set[EV_CNT]  = cnt_last;
          hw_set[EV_HALT] = halt_pend;
          st_d = (cnt_last || halt_pend) ? S_IDLE : S_RX_WAIT;
        end
      end
      S_TX_DMA: begin
        if (blen_empty) begin
          if (halt_pend) begin
            st_d = S_IDLE;
            hw_set[EV_HALT] = 1'b1;
          end else begin
            st_d = S_TX_WAIT;
          end
        end
      end
      S_TX_WAIT: begin
        if (ep_done) begin
          if (ep_err) begin
            st_d = S_IDLE;
            hw_set[EV_ERR] = 1'b1;
          end else begin
            pkt_done        = 1'b1;
            hw_set[EV_CNT]  = cnt_last;
            hw_set[EV_HALT] = halt_pend;
            if (cnt_last || halt_pend) begin
              st_d = S_IDLE;
            end else begin
              st_d      = S_TX_DMA;
              blen_load = 1'b1;
            end
          end
        end else if (halt_pend) begin
          st_d = S_IDLE;
          hw_set[EV_HALT] = 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
    if (hard_stop) begin
      st_d            = S_IDLE;
      hw_set          = '0;
      hw_set[EV_HALT] = 1'b1;
      pkt_done        = 1'b0;
      blen_load       = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      auto_q <= 1'b0;
      den_q  <= 1'b0;
      ign_q  <= 1'b0;
      dir_q  <= 1'b0;
      ntgl_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (hw_set != '0)            auto_q <= 1'b0;
      else if (ctl_we && start_ok) auto_q <= 1'b1;
      else if (ctl_we && !ctl_auto) auto_q <= 1'b0;
      if (ctl_we) begin
        den_q <= ctl_den;
        ign_q <= ctl_ign;
      end
      if (start_ok) dir_q <= ctl_dir;
      if (ctl_we)        ntgl_q <= ctl_tgl;
      else if (pkt_done) ntgl_q <= ~ntgl_q;
    end
  end

  aseq_evreg i_evreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_we   (ev_we),
    .clr_mask (ev_clr),
    .hw_set   (hw_set),
    .ev_q     (ev_bits),
    .irq      (irq)
  );

  aseq_pktcnt #(.CNT_W(CNT_W)) i_pktcnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_we),
    .load_val (cnt_wdata),
    .dec      (pkt_done),
    .last     (cnt_last)
  );

  aseq_bytecnt #(.LEN_W(LEN_W)) i_bytecnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (blen_load),
    .load_val (blen_val),
    .step     (dma_req && dma_ack),
    .empty    (blen_empty)
  );

  assign ep_flush  = (st_q == S_FLUSH);
  assign ep_rx_en  = (st_q == S_RX_WAIT);
  assign ep_tx_en  = (st_q == S_TX_WAIT);
  assign ep_tx_tgl = ntgl_q;
  assign dma_req   = in_dma && !blen_empty && den_q;
  assign dma_wr    = (st_q == S_RX_DMA);
  assign st_auto   = auto_q;
  assign st_den    = den_q;
  assign st_ntgl   = ntgl_q;

endmodule

// File: rtl/aseq_chk.sv
module aseq_chk
  import aseq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            st_auto,
  input logic            st_den,
  input logic            st_ntgl,
  input logic            dma_req,
  input logic            ep_rx_en,
  input logic            ep_tx_en,
  input logic            ep_flush,
  input logic            irq,
  input logic [EV_N-1:0] ev_bits,
  input logic [EV_N-1:0] hw_set,
  input logic            active,
  input logic            pkt_done,
  input logic            ctl_we
);

  AST_START_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_auto) |-> $past(!st_den && ev_bits == '0)); // R1

  AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ep_flush |=> !ep_flush); // R2

  AST_RX_OFF_DURING_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    !(ep_rx_en && dma_req)); // R3

  AST_TX_OFF_DURING_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    !(ep_tx_en && dma_req)); // R4

  AST_TGL_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && !ctl_we) |=> (st_ntgl != $past(st_ntgl))); // R5

  AST_HALT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_bits[EV_HALT]) |-> !active); // R9

  AST_REQ_NEEDS_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> st_den); // R10

  AST_EVENT_ENDS_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> !st_auto); // R11

  AST_IRQ_FROM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(hw_set != '0)); // R13

endmodule

bind aseq_top aseq_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .st_auto  (st_auto),
  .st_den   (st_den),
  .st_ntgl  (st_ntgl),
  .dma_req  (dma_req),
  .ep_rx_en (ep_rx_en),
  .ep_tx_en (ep_tx_en),
  .ep_flush (ep_flush),
  .irq      (irq),
  .ev_bits  (ev_bits),
  .hw_set   (hw_set),
  .active   (active),
  .pkt_done (pkt_done),
  .ctl_we   (ctl_we)
);

// File: tb/test_aseq_top.sv
module test_aseq_top;

  localparam int CLK_PERIOD = 10;
  localparam int PKT_MAX    = 8;
  localparam int CNT_W      = 8;
  localparam int LEN_W      = $clog2(PKT_MAX + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 0, ctl_auto = 0, ctl_den = 0, ctl_tgl = 0, ctl_ign = 0, ctl_dir = 0;
  logic ev_we = 0;
  logic [3:0] ev_clr = '0;
  logic cnt_we = 0;
  logic [CNT_W-1:0] cnt_wdata = '0;
  logic ep_done = 0, ep_err = 0, ep_rx_tgl = 0;
  logic [LEN_W-1:0] ep_len = '0;
  logic dma_ack = 0;
  logic ep_flush, ep_rx_en, ep_tx_en, ep_tx_tgl, dma_req, dma_wr;
  logic st_auto, st_den, st_ntgl, irq;
  logic [3:0] ev_bits;

  int total = 0;
  int bad = 0;
  int wr_bytes = 0;
  int rd_bytes = 0;
  logic ack_en = 1'b1;
  logic finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aseq_top #(.PKT_MAX(PKT_MAX), .CNT_W(CNT_W), .LEN_W(LEN_W)) i_aseq_top (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .ctl_auto(ctl_auto), .ctl_den(ctl_den), .ctl_tgl(ctl_tgl),
    .ctl_ign(ctl_ign), .ctl_dir(ctl_dir),
    .ev_we(ev_we), .ev_clr(ev_clr), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .ep_flush(ep_flush), .ep_rx_en(ep_rx_en), .ep_tx_en(ep_tx_en), .ep_tx_tgl(ep_tx_tgl),
    .ep_done(ep_done), .ep_err(ep_err), .ep_rx_tgl(ep_rx_tgl), .ep_len(ep_len),
    .dma_req(dma_req), .dma_wr(dma_wr), .dma_ack(dma_ack),
    .st_auto(st_auto), .st_den(st_den), .st_ntgl(st_ntgl), .ev_bits(ev_bits), .irq(irq)
  );

  // Memory model: acknowledge any request seen at the falling edge.
  always @(negedge clk) dma_ack = dma_req && ack_en;

  always @(posedge clk) begin
    if (dma_req && dma_ack) begin
      if (dma_wr) wr_bytes = wr_bytes + 1;
      else        rd_bytes = rd_bytes + 1;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl_write(input logic a, input logic d, input logic t, input logic ig, input logic dr);
    @(negedge clk);
    ctl_we = 1; ctl_auto = a; ctl_den = d; ctl_tgl = t; ctl_ign = ig; ctl_dir = dr;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic ev_clear(input logic [3:0] m);
    @(negedge clk);
    ev_we = 1; ev_clr = m;
    @(negedge clk);
    ev_we = 0; ev_clr = '0;
  endtask

  task automatic cnt_load(input int c);
    @(negedge clk);
    cnt_we = 1; cnt_wdata = CNT_W'(c);
    @(negedge clk);
    cnt_we = 0;
  endtask

  task automatic start_mode(input logic dr, input logic t, input logic ig);
    ctl_write(1'b0, 1'b0, t, ig, dr);
    ctl_write(1'b1, 1'b1, t, ig, dr);
  endtask

  task automatic ep_pulse(input int len, input logic tg, input logic er);
    @(negedge clk);
    ep_done = 1; ep_len = LEN_W'(len); ep_rx_tgl = tg; ep_err = er;
    @(negedge clk);
    ep_done = 0; ep_err = 0;
  endtask

  task automatic t_reset;
    chk("R13 irq after reset", int'(irq), 0);
    chk("R12 events after reset", int'(ev_bits), 0);
    chk("R1 auto after reset", int'(st_auto), 0);
    chk("R10 dma_req after reset", int'(dma_req), 0);
  endtask

  task automatic t_start_gate;
    cnt_load(2);
    ctl_write(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    ctl_write(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    wait_n(2);
    chk("R1 start refused with den set", int'(st_auto), 0);
    chk("R1 receiver stays off", int'(ep_rx_en), 0);
    start_mode(1'b0, 1'b0, 1'b0);
    chk("R2 flush pulse", int'(ep_flush), 1);
    chk("R2 auto status on", int'(st_auto), 1);
    wait_n(1);
    chk("R2 flush one cycle", int'(ep_flush), 0);
    chk("R2 receiver enabled", int'(ep_rx_en), 1);
  endtask

  task automatic t_rx_count;
    int w0;
    w0 = wr_bytes;
    ep_pulse(3, 1'b0, 1'b0);
    chk("R3 receiver off during DMA", int'(ep_rx_en), 0);
    chk("R3 dma direction write", int'(dma_wr), 1);
    wait_n(12);
    chk("R3 bytes of packet 1", wr_bytes - w0, 3);
    chk("R3 receiver re-enabled", int'(ep_rx_en), 1);
    chk("R5 toggle flipped", int'(st_ntgl), 1);
    ep_pulse(PKT_MAX, 1'b1, 1'b0);
    wait_n(15);
    chk("R3 total bytes", wr_bytes - w0, 3 + PKT_MAX);
    chk("R8 count event bit2", int'(ev_bits), 4'b0100);
    chk("R11 auto off after count", int'(st_auto), 0);
    chk("R5 toggle flipped twice", int'(st_ntgl), 0);
    chk("R13 irq outside auto", int'(irq), 1);
  endtask

  task automatic t_clear;
    ev_clear(4'b0001);
    chk("R12 clear of unset bit", int'(ev_bits), 4'b0100);
    ev_clear(4'b0100);
    chk("R12 count bit cleared", int'(ev_bits), 0);
    chk("R13 irq low", int'(irq), 0);
  endtask

  task automatic t_toggle;
    int w0;
    w0 = wr_bytes;
    start_mode(1'b0, 1'b1, 1'b0);
    chk("R5 write loads toggle", int'(st_ntgl), 1);
    ep_pulse(2, 1'b0, 1'b0);
    wait_n(4);
    chk("R6 mismatch error bit0", int'(ev_bits), 4'b0001);
    chk("R6 no bytes on mismatch", wr_bytes - w0, 0);
    chk("R11 auto off on mismatch", int'(st_auto), 0);
    ev_clear(4'b0001);
    start_mode(1'b0, 1'b1, 1'b1);
    ep_pulse(2, 1'b0, 1'b0);
    wait_n(8);
    chk("R6 ignore accepts packet", wr_bytes - w0, 2);
    chk("R6 still active", int'(st_auto), 1);
    chk("R5 toggle flip after ignore", int'(st_ntgl), 0);
    ctl_write(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    wait_n(2);
    chk("R9 halt bit3 from wait", int'(ev_bits), 4'b1000);
    chk("R9 receiver off after halt", int'(ep_rx_en), 0);
    ev_clear(4'b1000);
  endtask

  task automatic t_size_err;
    int w0;
    w0 = wr_bytes;
    start_mode(1'b0, 1'b0, 1'b0);
    ep_pulse(PKT_MAX + 1, 1'b0, 1'b0);
    wait_n(4);
    chk("R7 size bit1", int'(ev_bits), 4'b0010);
    chk("R7 no bytes oversize", wr_bytes - w0, 0);
    ev_clear(4'b0010);
    start_mode(1'b0, 1'b0, 1'b0);
    ep_pulse(2, 1'b0, 1'b1);
    wait_n(4);
    chk("R7 engine error bit0", int'(ev_bits), 4'b0001);
    chk("R7 no bytes on error", wr_bytes - w0, 0);
    ev_clear(4'b0001);
  endtask

  task automatic t_tx;
    int r0;
    r0 = rd_bytes;
    cnt_load(1);
    start_mode(1'b1, 1'b1, 1'b0);
    chk("R2 flush on transmit start", int'(ep_flush), 1);
    wait_n(1);
    chk("R4 transmitter off during DMA", int'(ep_tx_en), 0);
    wait_n(14);
    chk("R4 bytes read", rd_bytes - r0, PKT_MAX);
    chk("R4 transmitter enabled", int'(ep_tx_en), 1);
    chk("R4 tx toggle", int'(ep_tx_tgl), 1);
    ep_pulse(0, 1'b0, 1'b0);
    wait_n(1);
    chk("R8 count bit after one packet", int'(ev_bits), 4'b0100);
    chk("R5 toggle after tx packet", int'(st_ntgl), 0);
    ev_clear(4'b0100);
  endtask

  task automatic t_halt_dma;
    int r0;
    r0 = rd_bytes;
    ack_en = 1'b0;
    start_mode(1'b1, 1'b0, 1'b0);
    wait_n(3);
    chk("R4 request pending", int'(dma_req), 1);
    ctl_write(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    wait_n(3);
    chk("R9 DMA continues after halt", int'(dma_req), 1);
    chk("R9 no halt bit yet", int'(ev_bits), 0);
    ack_en = 1'b1;
    wait_n(15);
    chk("R9 burst finished", rd_bytes - r0, PKT_MAX);
    chk("R9 halt bit after burst", int'(ev_bits), 4'b1000);
    chk("R9 transmitter not enabled", int'(ep_tx_en), 0);
    ev_clear(4'b1000);
  endtask

  task automatic t_hard_stop;
    int r0;
    r0 = rd_bytes;
    ack_en = 1'b0;
    start_mode(1'b1, 1'b0, 1'b0);
    wait_n(3);
    ctl_write(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10 request dropped", int'(dma_req), 0);
    chk("R10 halt bit", int'(ev_bits), 4'b1000);
    chk("R10 den cleared", int'(st_den), 0);
    ack_en = 1'b1;
    wait_n(6);
    chk("R10 no bytes moved", rd_bytes - r0, 0);
    ev_clear(4'b1000);
  endtask

  task automatic t_clear_vs_set;
    start_mode(1'b0, 1'b0, 1'b0);
    wait_n(1);
    chk("R3 receiver ready", int'(ep_rx_en), 1);
    @(negedge clk);
    ep_done = 1; ep_err = 1; ep_len = '0; ev_we = 1; ev_clr = 4'b0001;
    @(negedge clk);
    ep_done = 0; ep_err = 0; ev_we = 0; ev_clr = '0;
    chk("R12 set wins over clear", int'(ev_bits), 4'b0001);
    chk("R13 irq with set", int'(irq), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_start_gate();
    t_rx_count();
    t_clear();
    t_toggle();
    t_size_err();
    t_tx();
    t_halt_dma();
    t_hard_stop();
    t_clear_vs_set();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule